// File: doc/BRIEF.md
# SPI burst transfer sequencer

This block is the transfer engine of an SPI master. It takes 32-bit words from a transmit FIFO and sends each one as a series of single-byte exchanges on SCLK, MOSI and MISO. The bytes that come back are packed into one receive word, which is pushed into a receive FIFO. The burst length is programmed in bits. It decides how many bytes each word sends and whether one burst runs on over several FIFO words. The FIFOs are outside the block: it sees a first-word-fall-through read side and a push side.

A transfer starts in one of two ways. Software raises the exchange request (`go`), or the start-mode-control input makes the engine drain the FIFO whenever it holds data. The engine runs only while this channel is SPI master. It reports each transfer completion and each receive overflow as a one-cycle pulse. When the transmit FIFO runs dry it drops the exchange request. When the waveform option selects multiple-burst mode, completion is reported only when the FIFO drains, not at the end of each burst.

Top module: `spi_burst_seq`

## Requirements
- R1: The burst length is `cfg_burst_m1 + 1` bits. At the start of each word, the remaining bit count is reloaded from that length only if it is zero or negative; otherwise it carries over from the previous word.
- R2: A word sends ceil(min(remaining bits, 32) / 8) bytes, and the remaining count drops by 8 after each byte. Byte lanes of the receive word that were not exchanged read as zero.
- R3: Byte k of a word (bits 8k+7:8k) is sent k-th, so the least-significant byte goes first. The byte received in that exchange is stored at bits 8k+7:8k of the receive word.
- R4: Byte exchanges use SPI mode 0, most-significant bit first. SCLK idles low. MOSI changes only on falling SCLK edges and MISO is sampled on rising edges. Each SCLK phase lasts HALF_DIV clock cycles.
- R5: When a receive word is complete, a high `rx_full` gives a one-cycle `rx_ovf` pulse and no push. Otherwise `rx_push` pulses with the word on `rx_data`.
- R6: Outside multiple-burst mode, `xfer_done` pulses after every word that brings the remaining count to zero or below.
- R7: Multiple-burst mode is `cfg_master & ~cfg_start_ctl & cfg_ss_wave`. In this mode `xch` is held at 1 while words are sent, and `xfer_done` pulses only when the transmit FIFO drains.
- R8: When the last queued word finishes, `xfer_done` pulses once and `xch` falls to 0. A `go` with an empty FIFO also gives one `xfer_done` pulse and leaves `xch` at 0.
- R9: `go` sets `xch`. Words are popped only while `cfg_master` is 1 and either `xch` or `cfg_start_ctl` is 1. With `cfg_master` at 0, queued words stay in the FIFO and `xch` stays set.
- R10: A new word is popped only after every byte of the previous word has been exchanged. No pop happens while a byte exchange is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_m1 | input | BURST_W | Burst length in bits, minus one |
| cfg_master | input | 1 | Selected channel is SPI master |
| cfg_start_ctl | input | 1 | Start-mode-control: send whenever the TX FIFO has data |
| cfg_ss_wave | input | 1 | Slave-select waveform bit of the selected channel |
| go | input | 1 | Exchange request pulse |
| xch | output | 1 | Exchange request state |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DATA_W | Head word of the transmit FIFO |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| rx_data | output | DATA_W | Assembled receive word |
| rx_ovf | output | 1 | Receive overflow pulse |
| xfer_done | output | 1 | Transfer-complete pulse |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
The bench uses DATA_W 32 and BURST_W 12, so it can program bursts of 8, 12, 32 and 40 bits. These cover single-byte words, a partial word with zeroed upper lanes, and a burst that carries over into the next word. HALF_DIV is set to 2, which puts the counting divider in the build instead of the bypass and gives a measurable 4-cycle SCLK period. MISO is looped back from MOSI, straight or inverted, so every received byte can be predicted from what was sent.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SEND = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_PUSH = 2'd3
   } seq_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   output logic [7:0] rx_byte,
   output logic       busy,
   output logic       done,
   output logic       sclk,
   output logic       mosi,
   input  logic       miso
);
   localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic       tick;
   logic [7:0] tx_sh;
   logic [2:0] bit_q;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  div_q <= '0;
            else if (!busy || div_q == DIV_W'(HALF_DIV-1)) div_q <= '0;
            else                                         div_q <= div_q + DIV_W'(1);
         end
         assign tick = (div_q == DIV_W'(HALF_DIV-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         sclk    <= 1'b0;
         tx_sh   <= '0;
         rx_byte <= '0;
         bit_q   <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy  <= 1'b1;
            tx_sh <= tx_byte;
            sclk  <= 1'b0;
            bit_q <= '0;
         end else if (busy && tick) begin
            if (!sclk) begin
               sclk    <= 1'b1;
               rx_byte <= {rx_byte[6:0], miso};
            end else begin
               sclk  <= 1'b0;
               tx_sh <= {tx_sh[6:0], 1'b0};
               if (bit_q == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_q <= bit_q + 3'd1;
               end
            end
         end
      end
   end

   assign mosi = tx_sh[7];

   // R4: SCLK rests low between exchanges
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
   // R4: MOSI holds while SCLK stays high
   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_burst_counter.sv
module spi_burst_counter #(
   parameter int BURST_W = 12,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BURST_W-1:0] cfg_len_m1,
   input  logic               load,
   input  logic               dec,
   output logic               exhausted,
   output logic               last_byte
);
   localparam int CNT_W  = BURST_W + 2;
   localparam int BYTES  = DATA_W / 8;
   localparam int BYTE_W = $clog2(BYTES) + 1;
   localparam logic [CNT_W-1:0] WORD_BITS = CNT_W'(DATA_W);

   logic signed [CNT_W-1:0] rem_q, eff;
   logic [CNT_W-1:0]        cfg_len, word_bits, nbytes;
   logic [BYTE_W-1:0]       left_q;

   always_comb begin
      cfg_len   = {2'b00, cfg_len_m1} + CNT_W'(1);
      eff       = exhausted ? $signed(cfg_len) : rem_q;
      word_bits = ($unsigned(eff) > WORD_BITS) ? WORD_BITS : $unsigned(eff);
      nbytes    = (word_bits + CNT_W'(7)) >> 3;
   end

   assign exhausted = rem_q[CNT_W-1] || (rem_q == '0);
   assign last_byte = (left_q == BYTE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         left_q <= '0;
      end else if (load) begin
         rem_q  <= eff;
         left_q <= nbytes[BYTE_W-1:0];
      end else if (dec) begin
         rem_q  <= rem_q - $signed(CNT_W'(8));
         left_q <= left_q - BYTE_W'(1);
      end
   end

   // R1: starting a word with nothing left reloads the configured length
   p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (load && exhausted) |=> ($unsigned(rem_q) == $past(cfg_len)));
   // R2: each exchanged byte consumes eight bits
   p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec |=> (rem_q == $past(rem_q) - $signed(CNT_W'(8))));
   // R2: never more byte exchanges than lanes in a word
   p_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= BYTE_W'(BYTES));
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq #(
   parameter int DATA_W   = 32,
   parameter int BURST_W  = 12,
   parameter int HALF_DIV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BURST_W-1:0] cfg_burst_m1,
   input  logic               cfg_master,
   input  logic               cfg_start_ctl,
   input  logic               cfg_ss_wave,
   input  logic               go,
   output logic               xch,
   input  logic               tx_empty,
   input  logic [DATA_W-1:0]  tx_data,
   output logic               tx_pop,
   input  logic               rx_full,
   output logic               rx_push,
   output logic [DATA_W-1:0]  rx_data,
   output logic               rx_ovf,
   output logic               xfer_done,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso
);
   import spi_seq_pkg::*;

   localparam int BYTES = DATA_W / 8;
   localparam int IDX_W = $clog2(BYTES);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if ((1 << BURST_W) < DATA_W) begin : g_bad_burst
         $error("BURST_W too narrow to express a full word");
      end
   endgenerate

   seq_state_t        st_q;
   logic              xch_q;
   logic [DATA_W-1:0] word_q, rx_acc;
   logic [IDX_W-1:0]  idx_q;
   logic              multi, run, start_word, empty_go;
   logic              byte_busy, byte_done, exhausted, last_byte;
   logic [7:0]        rx_byte;

   assign multi      = cfg_master & ~cfg_start_ctl & cfg_ss_wave;
   assign run        = cfg_master & (xch_q | cfg_start_ctl);
   assign start_word = (st_q == SQ_IDLE) && run && !tx_empty;
   assign empty_go   = (st_q == SQ_IDLE) && cfg_master && xch_q && tx_empty;
   assign tx_pop     = start_word;
   assign xch        = xch_q;

   spi_burst_counter #(.BURST_W(BURST_W), .DATA_W(DATA_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_len_m1 (cfg_burst_m1),
      .load       (start_word),
      .dec        (byte_done),
      .exhausted  (exhausted),
      .last_byte  (last_byte)
   );

   spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (st_q == SQ_SEND),
      .tx_byte (word_q[7:0]),
      .rx_byte (rx_byte),
      .busy    (byte_busy),
      .done    (byte_done),
      .sclk    (sclk),
      .mosi    (mosi),
      .miso    (miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         xch_q     <= 1'b0;
         word_q    <= '0;
         rx_acc    <= '0;
         idx_q     <= '0;
         rx_push   <= 1'b0;
         rx_data   <= '0;
         rx_ovf    <= 1'b0;
         xfer_done <= 1'b0;
      end else begin
         rx_push   <= 1'b0;
         rx_ovf    <= 1'b0;
         xfer_done <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (start_word) begin
                  word_q <= tx_data;
                  rx_acc <= '0;
                  idx_q  <= '0;
                  if (multi) xch_q <= 1'b1;
                  st_q   <= SQ_SEND;
               end else if (empty_go) begin
                  xch_q     <= 1'b0;
                  xfer_done <= 1'b1;
               end
            end
            SQ_SEND: st_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (byte_done) begin
                  rx_acc[{idx_q, 3'b000} +: 8] <= rx_byte;
                  idx_q  <= idx_q + IDX_W'(1);
                  word_q <= word_q >> 8;
                  st_q   <= last_byte ? SQ_PUSH : SQ_SEND;
               end
            end
            default: begin
               if (rx_full) rx_ovf <= 1'b1;
               else begin
                  rx_push <= 1'b1;
                  rx_data <= rx_acc;
               end
               if ((exhausted && !multi) || tx_empty) xfer_done <= 1'b1;
               if (tx_empty) xch_q <= 1'b0;
               st_q <= SQ_IDLE;
            end
         endcase
         if (go) xch_q <= 1'b1;
      end
   end

   // R10: the FIFO is never popped during a byte exchange
   p_no_pop_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      byte_busy |-> !tx_pop);
   // R5: a finished word is either pushed or flagged, never both
   p_push_xor_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_push && rx_ovf));
   // R8: the exchange request only drops together with a completion pulse
   p_xch_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xch_q) |-> xfer_done);
   // R3: a receive word leaves only after its last byte came back
   p_push_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> $past(byte_done, 2));
endmodule

// File: tb/tb_spi_burst_seq.sv
`timescale 1ns/1ps
module tb_spi_burst_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_burst_m1 = 12'd31;
   logic        cfg_master = 1'b1, cfg_start_ctl = 1'b0, cfg_ss_wave = 1'b0;
   logic        go = 1'b0, rx_full = 1'b0, inv = 1'b0;
   logic        xch, tx_pop, rx_push, rx_ovf, xfer_done, sclk, mosi, miso, tx_empty;
   logic [31:0] tx_data, rx_data;

   logic [31:0] txq [0:15];
   int th = 0, tt = 0;
   logic [31:0] rxw [0:63];
   int nrx = 0, ndone = 0, novf = 0, nrise = 0, npop = 0, ncap = 0;
   int pop_rise [0:63];
   logic [7:0] capb [0:255];
   logic [7:0] cap_sh = 8'h00;
   realtime rise_t [0:255];
   int checks = 0, errors = 0;

   logic [31:0] wlist [0:15];
   logic [31:0] exp_rx [0:15];
   int exp_done, exp_bytes;

   always #2.5 clk = ~clk;

   assign tx_empty = (th == tt);
   assign tx_data  = txq[th % 16];
   assign miso     = mosi ^ inv;

   spi_burst_seq #(.DATA_W(32), .BURST_W(12), .HALF_DIV(2)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_burst_m1(cfg_burst_m1), .cfg_master(cfg_master),
      .cfg_start_ctl(cfg_start_ctl), .cfg_ss_wave(cfg_ss_wave), .go(go), .xch(xch),
      .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
      .rx_push(rx_push), .rx_data(rx_data), .rx_ovf(rx_ovf), .xfer_done(xfer_done),
      .sclk(sclk), .mosi(mosi), .miso(miso));

   always @(posedge clk) begin
      if (tx_pop) begin
         th <= th + 1;
         pop_rise[npop] <= nrise;
         npop <= npop + 1;
      end
      if (rx_push) begin
         rxw[nrx] <= rx_data;
         nrx <= nrx + 1;
      end
      if (xfer_done) ndone <= ndone + 1;
      if (rx_ovf) novf <= novf + 1;
   end

   always @(posedge sclk) begin
      rise_t[nrise % 256] = $realtime;
      cap_sh = {cap_sh[6:0], mosi};
      nrise = nrise + 1;
      if (nrise % 8 == 0) begin
         capb[ncap % 256] = cap_sh;
         ncap = ncap + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic push_word(input int k, input logic [31:0] w);
      wlist[k] = w;
      txq[tt % 16] = w;
      tt = tt + 1;
   endtask

   task automatic pulse_go();
      @(negedge clk) go = 1'b1;
      @(negedge clk) go = 1'b0;
   endtask

   task automatic wait_drain();
      while (th != tt) @(negedge clk);
      repeat (200) @(negedge clk);
   endtask

   // expectation from R1, R2, R3, R6, R7, R8
   task automatic model(input int len, input int n, input bit multi_m);
      int rem = 0;
      exp_done = 0;
      exp_bytes = 0;
      for (int w = 0; w < n; w++) begin
         int wb, nb;
         if (rem <= 0) rem = len;
         wb = (rem > 32) ? 32 : rem;
         nb = (wb + 7) / 8;
         rem = rem - 8 * nb;
         exp_bytes += nb;
         exp_rx[w] = 32'h0;
         for (int b = 0; b < nb; b++)
            exp_rx[w][8*b +: 8] = wlist[w][8*b +: 8] ^ {8{inv}};
         if ((rem <= 0 && !multi_m) || w == n - 1) exp_done++;
      end
   endtask

   task automatic check_run(input string req, input int n, input int rx0,
                            input int done0, input int rise0);
      chk(nrx - rx0 == n, req, "receive word count", nrx - rx0, n);
      for (int w = 0; w < n; w++)
         chk(rxw[rx0 + w] == exp_rx[w], req, "receive word", rxw[rx0 + w], exp_rx[w]);
      chk(ndone - done0 == exp_done, req, "completion pulses", ndone - done0, exp_done);
      chk(nrise - rise0 == 8 * exp_bytes, req, "SCLK rising edges", nrise - rise0, 8 * exp_bytes);
      chk(xch == 1'b0, "R8", "xch after drain", xch, 0);
   endtask

   task automatic t_reset();
      chk(sclk == 1'b0, "R4", "reset sclk", sclk, 0);
      chk(xch == 1'b0, "R8", "reset xch", xch, 0);
      chk(tx_pop == 1'b0, "R9", "reset pop", tx_pop, 0);
      chk(rx_push == 1'b0 && rx_ovf == 1'b0 && xfer_done == 1'b0, "R5", "reset pulses", 0, 0);
   endtask

   task automatic t_full_words();
      int rx0 = nrx, d0 = ndone, r0 = nrise, p0 = npop;
      cfg_burst_m1 = 12'd31; inv = 1'b0;
      push_word(0, 32'h1234_5678);
      push_word(1, 32'h9ABC_DEF0);
      model(32, 2, 1'b0);
      pulse_go();
      wait_drain();
      check_run("R6", 2, rx0, d0, r0);
      // R10: second pop only after the 32 bits of the first word
      chk(pop_rise[p0 + 1] - r0 == 32, "R10", "rises before second pop", pop_rise[p0 + 1] - r0, 32);
   endtask

   task automatic t_short_burst();
      int rx0 = nrx, d0 = ndone, r0 = nrise, c0 = ncap;
      cfg_burst_m1 = 12'd11; inv = 1'b1;
      push_word(0, 32'hA1B2_C3D4);
      model(12, 1, 1'b0);
      pulse_go();
      wait_drain();
      check_run("R2", 1, rx0, d0, r0);
      // R3 low byte first, R4 MSB first within a byte
      chk(capb[c0 % 256] == 8'hD4, "R3", "first byte on MOSI", capb[c0 % 256], 8'hD4);
      chk(capb[(c0 + 1) % 256] == 8'hC3, "R4", "second byte on MOSI", capb[(c0 + 1) % 256], 8'hC3);
      chk(rise_t[(r0 + 1) % 256] - rise_t[r0 % 256] == 20.0, "R4", "SCLK period ns",
          longint'(rise_t[(r0 + 1) % 256] - rise_t[r0 % 256]), 20);
      inv = 1'b0;
   endtask

   task automatic t_span();
      int rx0 = nrx, d0 = ndone, r0 = nrise;
      cfg_burst_m1 = 12'd39;
      for (int k = 0; k < 4; k++) push_word(k, 32'h0101_0101 * (k + 3));
      model(40, 4, 1'b0);
      pulse_go();
      wait_drain();
      check_run("R1", 4, rx0, d0, r0);
   endtask

   task automatic t_multi();
      int rx0 = nrx, d0 = ndone, r0 = nrise;
      cfg_burst_m1 = 12'd39; cfg_ss_wave = 1'b1;
      for (int k = 0; k < 4; k++) push_word(k, 32'hC0DE_0000 + k);
      model(40, 4, 1'b1);
      pulse_go();
      repeat (20) @(negedge clk);
      chk(xch == 1'b1, "R7", "xch held mid run", xch, 1);
      wait_drain();
      check_run("R7", 4, rx0, d0, r0);
      cfg_ss_wave = 1'b0;
   endtask

   task automatic t_byte();
      int rx0 = nrx, d0 = ndone, r0 = nrise;
      cfg_burst_m1 = 12'd7; inv = 1'b1;
      push_word(0, 32'h0000_00A5);
      push_word(1, 32'hFFFF_FF3C);
      push_word(2, 32'h1234_5601);
      model(8, 3, 1'b0);
      pulse_go();
      wait_drain();
      check_run("R2", 3, rx0, d0, r0);
      inv = 1'b0;
   endtask

   task automatic t_ovf();
      int rx0 = nrx, o0 = novf;
      cfg_burst_m1 = 12'd31; rx_full = 1'b1;
      push_word(0, 32'h5555_AAAA);
      push_word(1, 32'h0F0F_F0F0);
      pulse_go();
      wait_drain();
      chk(novf - o0 == 2, "R5", "overflow pulses", novf - o0, 2);
      chk(nrx == rx0, "R5", "pushes while full", nrx - rx0, 0);
      rx_full = 1'b0;
   endtask

   task automatic t_slave();
      int rx0 = nrx, d0 = ndone, r0 = nrise, p0 = npop;
      cfg_burst_m1 = 12'd31; cfg_master = 1'b0;
      push_word(0, 32'hDEAD_BEEF);
      model(32, 1, 1'b0);
      pulse_go();
      repeat (100) @(negedge clk);
      chk(npop == p0, "R9", "pops while not master", npop - p0, 0);
      chk(nrise == r0, "R9", "SCLK edges while not master", nrise - r0, 0);
      chk(xch == 1'b1, "R9", "xch kept while not master", xch, 1);
      cfg_master = 1'b1;
      wait_drain();
      check_run("R9", 1, rx0, d0, r0);
   endtask

   task automatic t_auto();
      int rx0 = nrx, d0 = ndone, r0 = nrise;
      cfg_burst_m1 = 12'd31; cfg_start_ctl = 1'b1;
      @(negedge clk);
      push_word(0, 32'h8765_4321);
      push_word(1, 32'h0BAD_F00D);
      model(32, 2, 1'b0);
      wait_drain();
      check_run("R9", 2, rx0, d0, r0);
      cfg_start_ctl = 1'b0;
   endtask

   task automatic t_empty_go();
      int d0 = ndone, r0 = nrise;
      pulse_go();
      repeat (5) @(negedge clk);
      chk(ndone - d0 == 1, "R8", "completion on empty go", ndone - d0, 1);
      chk(xch == 1'b0, "R8", "xch after empty go", xch, 0);
      chk(nrise == r0, "R8", "no SCLK on empty go", nrise - r0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_full_words();
      t_short_burst();
      t_span();
      t_multi();
      t_byte();
      t_ovf();
      t_slave();
      t_auto();
      t_empty_go();
      finish_up();
   end
endmodule